// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Capture Sequencer

This block controls an external multi-channel ADC that samples all of its inputs at the same instant. It raises a conversion-start pin, waits for the converter's busy line to fall, and then fetches one sample per channel through a parallel read strobe on a 16-bit bus. Each sample leaves on a valid/ready stream that carries its channel index, with an end-of-frame flag on the last channel. The block also drives the converter's reset, oversampling-code, input-range and standby pins. Conversions run one at a time on a start pulse, or back to back while continuous mode is enabled.

The sequencer checks that frames stay aligned. When channel 0 is read, the converter's first-channel marker must be high. If the marker is low, the frame is dropped, an error pulse is raised and the converter is reset. On the 16-channel variant, a new oversampling code also causes a reset. On that variant, every reset is followed by a long quiet period before the next conversion may start.

The controller is one state machine. Its states are:
- RESET_PULSE: drives the reset pin.
- SETTLE: the quiet period, used on the 16-channel variant only.
- IDLE.
- CONVERT: conversion-start high, waiting for busy to fall.
- READ: strobe high for one sample.
- PRESENT: the sample is offered on the stream.
- ALIGN_FAULT: one-cycle error state.
- TIMEOUT: one-cycle error state.
- STANDBY.

Its transitions are:
- RESET_PULSE goes to SETTLE when the variant has 16 channels, and to IDLE otherwise. SETTLE goes to IDLE.
- From IDLE the block goes to STANDBY on a standby request. Otherwise, a new oversampling code goes to RESET_PULSE on 16 channels, or is applied in IDLE on the other variants. Otherwise, a start pulse or continuous enable goes to CONVERT.
- From CONVERT the block goes to READ on the falling edge of busy. It goes to IDLE when continuous mode is cleared during a continuous conversion. It goes to TIMEOUT when the single-shot window expires.
- From READ the block goes to ALIGN_FAULT on a bad marker, and to PRESENT otherwise.
- From PRESENT, an accepted sample goes to READ for the next channel, or to IDLE after the last one.
- ALIGN_FAULT goes to RESET_PULSE. TIMEOUT goes to IDLE.
- STANDBY goes to RESET_PULSE when the request is released.

Top module: `adc_capture_seq`

## Requirements
- R1: Reset state and first pulse.
  - While and after reset, conversion-start, stream valid and both error flags are low.
  - The range pin is low and the standby pin (active low) is high.
  - The oversampling pins read 0.
  - A converter reset pulse is issued first.
- R2: Start of a conversion.
  - A start pulse in IDLE raises conversion-start, or an asserted continuous enable does the same.
  - Conversion-start stays high until busy falls.
  - Conversion-start is low whenever the read strobe is high.
- R3: Frame readout.
  - Each sample asserts the read strobe for RD_CYC cycles, and the data bus is captured in the last strobe cycle.
  - The samples leave the block in channel order 0 to NUM_CH-1.
  - The channel index goes on the channel output, and end-of-frame is high only with channel NUM_CH-1.
- R4: Backpressure.
  - While valid is high and ready is low, the data and channel outputs hold and valid stays high.
  - The read strobe and conversion-start stay low.
  - No new conversion starts until the last sample of the frame has been accepted.
- R5: Alignment fault.
  - If the first-channel marker is low when channel 0 is captured, no sample of that frame is offered.
  - The alignment error output pulses for one cycle, and a converter reset pulse follows in the next cycle.
- R6: Every converter reset pulse lasts ceil(RST_NS / CLK_NS) cycles, which is 13 cycles at 8 ns.
- R7: Oversampling code.
  - In IDLE the three oversampling pins take the requested code. Codes 0 to 6 select ratios 1 to 64, and code 7 selects 128.
  - On the 16-channel variant, any change of code issues a converter reset.
  - On the other variants, code 7 is driven as 6 and no reset is issued.
- R8: On the 16-channel variant, conversion-start does not rise within SETTLE_US microseconds (SETTLE_CYC cycles) of the falling edge of a reset pulse.
- R9: Range.
  - The range pin follows the stored range request, which is sampled in IDLE.
  - Low selects ±5 V and high selects ±10 V.
- R10: Single-shot timeout.
  - If busy has not fallen TIMEOUT_US microseconds after conversion-start rose, the timeout output pulses once.
  - Conversion-start drops and the block returns to IDLE.
- R11: Continuous mode.
  - While continuous enable is high, conversion-start rises again after each frame has been accepted.
  - Clearing the enable holds conversion-start low, and a conversion that is waiting is abandoned.
- R12: Standby.
  - On a standby request the standby pin goes low and the range pin is forced high.
  - On release, the standby pin returns high, the stored range is driven and a converter reset pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-shot conversion request (pulse) |
| cont_en | input | 1 | Continuous conversion enable |
| os_code | input | 3 | Requested oversampling code |
| range_sel | input | 1 | Requested range: 0 = ±5 V, 1 = ±10 V |
| standby_req | input | 1 | Request to put the converter in standby |
| adc_busy | input | 1 | Converter busy |
| adc_first | input | 1 | First-channel marker |
| adc_data | input | DATA_W | Parallel sample bus |
| adc_convst | output | 1 | Conversion start |
| adc_reset | output | 1 | Converter reset pulse |
| adc_os | output | 3 | Oversampling code pins |
| adc_range | output | 1 | Range pin |
| adc_stby_n | output | 1 | Standby pin, low = standby |
| adc_rd | output | 1 | Read strobe |
| s_valid | output | 1 | Stream valid |
| s_ready | input | 1 | Stream ready |
| s_data | output | DATA_W | Sample value |
| s_chan | output | CH_W | Channel index of the sample |
| s_last | output | 1 | Last channel of the frame |
| err_align | output | 1 | One-cycle alignment error pulse |
| err_timeout | output | 1 | One-cycle timeout pulse |

## Verification
The in-line properties check several behaviours on every cycle:
- The read strobe and conversion-start are never high together.
- A stalled sample holds still, and the strobe stays idle under backpressure.
- The range pin is high during standby.
- A reset pulse follows an alignment error.
- No code 7 appears on the smaller variants.
- The settle window after each reset is kept, using a counter.

Other behaviours depend on the external converter, so only the bench scenarios show them:
- Sample values and channel order.
- Strobe width and reset pulse width.
- The discarded frame after an injected misalignment.
- The timeout when busy never rises.
- Repeated conversions in continuous mode.
- The range restored after standby.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        S_RST,
        S_SETTLE,
        S_IDLE,
        S_CONV,
        S_READ,
        S_PRESENT,
        S_ALIGN,
        S_TMO,
        S_STBY
    } seq_state_t;

    // Clamp the oversampling code to what the variant supports.
    function automatic logic [2:0] os_limit(input logic [2:0] code, input int nch);
        if (nch != 16 && code == 3'd7) begin
            return 3'd6;
        end
        return code;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W    = 32,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(INIT);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/frame_slot.sv
module frame_slot #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              advance,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [CH_W-1:0]   chan,
    output logic              at_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
            chan <= '0;
        end else begin
            if (capture) begin
                dout <= din;
            end
            if (clear) begin
                chan <= '0;
            end else if (advance) begin
                chan <= chan + 1'b1;
            end
        end
    end

    assign at_last = (chan == CH_W'(NUM_CH - 1));
endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int DATA_W     = 16,
    parameter int CLK_NS     = 8,
    parameter int RST_NS     = 100,
    parameter int SETTLE_US  = 15000,
    parameter int TIMEOUT_US = 1000000,
    parameter int RD_CYC     = 2,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont_en,
    input  logic [2:0]        os_code,
    input  logic              range_sel,
    input  logic              standby_req,
    input  logic              adc_busy,
    input  logic              adc_first,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_convst,
    output logic              adc_reset,
    output logic [2:0]        adc_os,
    output logic              adc_range,
    output logic              adc_stby_n,
    output logic              adc_rd,
    output logic              s_valid,
    input  logic              s_ready,
    output logic [DATA_W-1:0] s_data,
    output logic [CH_W-1:0]   s_chan,
    output logic              s_last,
    output logic              err_align,
    output logic              err_timeout
);
    localparam int TW         = 32;
    localparam int RST_CYC    = (RST_NS + CLK_NS - 1) / CLK_NS;
    localparam int SETTLE_CYC = (SETTLE_US * 1000) / CLK_NS;
    localparam int TMO_CYC    = (TIMEOUT_US * 1000) / CLK_NS;
    localparam bit WIDE_PART  = (NUM_CH == 16);

    seq_state_t state_q, state_d;
    logic       busy_q, range_q, cont_q;
    logic [2:0] os_q, os_want;
    logic       tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic       busy_fall, at_last, slot_capture, slot_advance, slot_clear;

    assign os_want   = os_limit(os_code, NUM_CH);
    assign busy_fall = busy_q && !adc_busy;

    seq_timer #(.W(TW), .INIT(RST_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    frame_slot #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (slot_clear),
        .capture (slot_capture),
        .advance (slot_advance),
        .din     (adc_data),
        .dout    (s_data),
        .chan    (s_chan),
        .at_last (at_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // Stored settings and busy history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            range_q <= 1'b0;
            os_q    <= 3'd0;
            cont_q  <= 1'b0;
        end else begin
            busy_q <= adc_busy;
            if (state_q == S_IDLE) begin
                range_q <= range_sel;
                if (!standby_req) begin
                    os_q <= os_want;
                end
                cont_q <= cont_en;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RST:     if (tmr_exp) state_d = WIDE_PART ? S_SETTLE : S_IDLE;
            S_SETTLE:  if (tmr_exp) state_d = S_IDLE;
            S_IDLE: begin
                if (standby_req) begin
                    state_d = S_STBY;
                end else if (os_want != os_q) begin
                    state_d = WIDE_PART ? S_RST : S_IDLE;
                end else if (start || cont_en) begin
                    state_d = S_CONV;
                end
            end
            S_CONV: begin
                if (busy_fall) begin
                    state_d = S_READ;
                end else if (cont_q && !cont_en) begin
                    state_d = S_IDLE;
                end else if (!cont_q && tmr_exp) begin
                    state_d = S_TMO;
                end
            end
            S_READ: begin
                if (tmr_exp) begin
                    state_d = (s_chan == '0 && !adc_first) ? S_ALIGN : S_PRESENT;
                end
            end
            S_PRESENT: if (s_ready) state_d = at_last ? S_IDLE : S_READ;
            S_ALIGN:   state_d = S_RST;
            S_TMO:     state_d = S_IDLE;
            S_STBY:    if (!standby_req) state_d = S_RST;
            default:   state_d = S_RST;
        endcase
    end

    // Timer load on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            S_RST:    tmr_val = TW'(RST_CYC - 1);
            S_SETTLE: tmr_val = TW'(SETTLE_CYC - 1);
            S_CONV:   tmr_val = TW'(TMO_CYC - 1);
            S_READ:   tmr_val = TW'(RD_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    // Outputs
    always_comb begin
        adc_reset    = (state_q == S_RST);
        adc_convst   = (state_q == S_CONV);
        adc_rd       = (state_q == S_READ);
        adc_stby_n   = (state_q != S_STBY);
        adc_range    = (state_q == S_STBY) ? 1'b1 : range_q;
        adc_os       = os_q;
        s_valid      = (state_q == S_PRESENT);
        s_last       = s_valid && at_last;
        err_align    = (state_q == S_ALIGN);
        err_timeout  = (state_q == S_TMO);
        slot_clear   = (state_q == S_CONV);
        slot_capture = (state_q == S_READ) && tmr_exp;
        slot_advance = (state_q == S_PRESENT) && s_ready && !at_last;
    end

    // ---------------- assertions ----------------
    logic [TW-1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (adc_reset) begin
            since_rst_q <= '0;
        end else if (since_rst_q < TW'(SETTLE_CYC)) begin
            since_rst_q <= since_rst_q + 1'b1;
        end
    end

    p_rd_no_convst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd |-> !adc_convst);

    p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_ready) |=> (s_valid && $stable(s_data) && $stable(s_chan)));

    p_idle_pins_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> (!adc_rd && !adc_convst));

    p_reset_after_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_align |=> adc_reset);

    p_os_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_os != 3'd7) || WIDE_PART);

    p_settle_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_convst) |-> (!WIDE_PART || since_rst_q >= TW'(SETTLE_CYC)));

    p_timeout_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> (!adc_convst && !s_valid));

    p_stby_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_stby_n |-> adc_range);
endmodule

// File: tb/adc_capture_seq_tb_top.sv
module adc_capture_seq_tb_top;
    localparam int NCH = 16;
    localparam int RST_CYC = 13;
    localparam int SETTLE_CYC = 250;
    localparam int RD_CYC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, cont_en = 0, range_sel = 0, standby_req = 0, s_ready = 1;
    logic [2:0] os_code = 3'd0;
    logic adc_busy = 0, adc_first = 1;
    logic [15:0] adc_data = '0;
    logic adc_convst, adc_reset, adc_range, adc_stby_n, adc_rd;
    logic [2:0] adc_os;
    logic s_valid, s_last, err_align, err_timeout;
    logic [15:0] s_data;
    logic [3:0] s_chan;

    // Second instance: 4-channel variant, used for the code-7 clamp
    logic [2:0] os_code4 = 3'd0;
    logic c4_convst, c4_reset, c4_range, c4_stby_n, c4_rd, c4_valid, c4_last, c4_ea, c4_et;
    logic [2:0] c4_os;
    logic [15:0] c4_data;
    logic [1:0] c4_chan;

    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    adc_capture_seq #(.NUM_CH(NCH), .SETTLE_US(2), .TIMEOUT_US(4), .RD_CYC(RD_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cont_en(cont_en), .os_code(os_code),
        .range_sel(range_sel), .standby_req(standby_req), .adc_busy(adc_busy),
        .adc_first(adc_first), .adc_data(adc_data), .adc_convst(adc_convst),
        .adc_reset(adc_reset), .adc_os(adc_os), .adc_range(adc_range),
        .adc_stby_n(adc_stby_n), .adc_rd(adc_rd), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_chan(s_chan), .s_last(s_last), .err_align(err_align),
        .err_timeout(err_timeout));

    adc_capture_seq #(.NUM_CH(4)) dut4_i (
        .clk(clk), .rst_n(rst_n), .start(1'b0), .cont_en(1'b0), .os_code(os_code4),
        .range_sel(1'b0), .standby_req(1'b0), .adc_busy(1'b0), .adc_first(1'b0),
        .adc_data(16'h0), .adc_convst(c4_convst), .adc_reset(c4_reset), .adc_os(c4_os),
        .adc_range(c4_range), .adc_stby_n(c4_stby_n), .adc_rd(c4_rd), .s_valid(c4_valid),
        .s_ready(1'b1), .s_data(c4_data), .s_chan(c4_chan), .s_last(c4_last),
        .err_align(c4_ea), .err_timeout(c4_et));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // ---------------- converter model ----------------
    int frame = 0, ptr = 0, dly = 0, busy_left = 0;
    int skip_req = 0, skip_done = 0;
    bit no_busy = 0, conv_prev = 0, rd_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_convst && !conv_prev && !no_busy && busy_left == 0 && dly == 0) dly = 3;
            if (dly > 0) begin
                dly--;
                if (dly == 0) begin adc_busy = 1; busy_left = 20; end
            end else if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    adc_busy = 0;
                    frame++;
                    if (skip_req > skip_done) begin ptr = 1; skip_done++; end
                    else ptr = 0;
                end
            end
            if (rd_prev && !adc_rd) ptr++;
            if (adc_reset) ptr = 0;
            conv_prev = adc_convst;
            rd_prev = adc_rd;
        end
        adc_first = (ptr == 0);
        adc_data = 16'hA000 + 16'(frame * 16) + 16'(ptr);
    end

    // ---------------- reference monitor ----------------
    int rst_run = 0, since = 100000, rst_cnt = 0, conv_rises = 0, rd_run = 0;
    int exp_chan = 0, samples = 0, frames_done = 0, al_cnt = 0, to_cnt = 0, c4_rises = 0;
    bit m_conv_prev = 0, m_rd_prev = 0, stall_prev = 0, c4_prev = 1;
    logic [15:0] data_prev;
    logic [3:0] chan_prev;

    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_reset) rst_run++;
            else if (rst_run > 0) begin
                chk(rst_run == RST_CYC, "R6 reset width", rst_run, RST_CYC);
                rst_run = 0; since = 1; rst_cnt++;
            end else since++;
            if (adc_convst && !m_conv_prev) begin
                chk(since >= SETTLE_CYC, "R8 settle", since, SETTLE_CYC);
                conv_rises++;
            end
            if (adc_rd) begin
                rd_run++;
                chk(!adc_convst, "R2 convst low during read", adc_convst, 0);
            end else if (m_rd_prev) begin
                chk(rd_run == RD_CYC, "R3 strobe width", rd_run, RD_CYC);
                rd_run = 0;
            end
            if (stall_prev)
                chk(s_valid && s_data == data_prev && s_chan == chan_prev,
                    "R4 hold under stall", int'(s_data), int'(data_prev));
            if (s_valid) chk(!adc_rd && !adc_convst, "R4 pins idle", {adc_rd, adc_convst}, 0);
            if (s_valid && s_ready) begin
                chk(int'(s_chan) == exp_chan, "R3 channel", s_chan, exp_chan);
                chk(s_data == 16'hA000 + 16'(frame * 16) + 16'(exp_chan), "R3 data",
                    s_data, 16'hA000 + frame * 16 + exp_chan);
                chk(s_last == (exp_chan == NCH - 1), "R3 last", s_last, exp_chan == NCH - 1);
                samples++;
                if (exp_chan == NCH - 1) begin exp_chan = 0; frames_done++; end
                else exp_chan++;
            end
            if (!adc_stby_n) chk(adc_range, "R12 range forced", adc_range, 1);
            if (err_align) begin al_cnt++; exp_chan = 0; end
            if (err_timeout) to_cnt++;
            if (c4_reset && !c4_prev) c4_rises++;
        end
        c4_prev = c4_reset;
        m_conv_prev = adc_convst;
        m_rd_prev = adc_rd;
        stall_prev = s_valid && !s_ready;
        data_prev = s_data;
        chan_prev = s_chan;
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1;
        @(posedge clk); #1 start = 0;
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 4000 && frames_done < target; i++) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int f0, r0, a0, s0, t0, c0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk(adc_reset && !adc_convst && !s_valid && !adc_range && adc_stby_n && adc_os == 0
            && !err_align && !err_timeout, "R1 reset state",
            {adc_reset, adc_convst, s_valid, adc_range, adc_stby_n}, 5'b10001);
        @(posedge clk); #1 os_code4 = 3'd7;
        repeat (300) @(posedge clk);

        // R2 / R3: single shot
        f0 = frames_done; c0 = conv_rises;
        pulse_start();
        wait_frames(f0 + 1);
        chk(frames_done == f0 + 1, "R2 single frame", frames_done, f0 + 1);
        chk(conv_rises == c0 + 1, "R2 one conversion", conv_rises, c0 + 1);

        // R4: backpressure
        f0 = frames_done; c0 = conv_rises;
        pulse_start();
        for (int i = 0; i < 300; i++) begin @(posedge clk); #1 s_ready = (i % 3 == 0); end
        chk(conv_rises == c0 + 1, "R4 no new conversion", conv_rises, c0 + 1);
        s_ready = 1;
        wait_frames(f0 + 1);
        chk(frames_done == f0 + 1, "R4 frame complete", frames_done, f0 + 1);

        // R9: range
        range_sel = 1; repeat (5) @(posedge clk); @(negedge clk);
        chk(adc_range == 1, "R9 range high", adc_range, 1);
        range_sel = 0; repeat (5) @(posedge clk); @(negedge clk);
        chk(adc_range == 0, "R9 range low", adc_range, 0);
        range_sel = 1; repeat (5) @(posedge clk);

        // R12: standby
        r0 = rst_cnt;
        standby_req = 1; repeat (5) @(posedge clk); @(negedge clk);
        chk(!adc_stby_n && adc_range, "R12 standby pins", {adc_stby_n, adc_range}, 2'b01);
        range_sel = 0;
        repeat (5) @(posedge clk); @(negedge clk);
        chk(adc_range == 1, "R12 forced during standby", adc_range, 1);
        #1 standby_req = 0;
        for (int i = 0; i < 10 && !adc_reset; i++) @(negedge clk);
        chk(adc_reset && adc_stby_n && adc_range, "R12 exit restores range",
            {adc_reset, adc_stby_n, adc_range}, 3'b111);
        repeat (300) @(posedge clk);
        chk(rst_cnt == r0 + 1, "R12 reset on exit", rst_cnt, r0 + 1);

        // R7: oversampling change resets the 16-channel part
        r0 = rst_cnt; os_code = 3'd3;
        repeat (5) @(posedge clk); @(negedge clk);
        chk(adc_os == 3'd3, "R7 os code", adc_os, 3);
        repeat (300) @(posedge clk);
        chk(rst_cnt == r0 + 1, "R7 reset on change", rst_cnt, r0 + 1);
        os_code = 3'd7;
        repeat (300) @(posedge clk); @(negedge clk);
        chk(adc_os == 3'd7, "R7 ratio 128", adc_os, 7);
        f0 = frames_done;
        pulse_start();
        wait_frames(f0 + 1);
        chk(frames_done == f0 + 1, "R8 frame after settle", frames_done, f0 + 1);

        // R5: misalignment
        r0 = rst_cnt; a0 = al_cnt; s0 = samples;
        skip_req++;
        pulse_start();
        repeat (400) @(posedge clk);
        chk(al_cnt == a0 + 1, "R5 error pulse", al_cnt, a0 + 1);
        chk(samples == s0, "R5 frame discarded", samples, s0);
        chk(rst_cnt == r0 + 1, "R5 reset issued", rst_cnt, r0 + 1);
        f0 = frames_done;
        pulse_start();
        wait_frames(f0 + 1);
        chk(frames_done == f0 + 1, "R5 recovery", frames_done, f0 + 1);

        // R10: timeout
        no_busy = 1; t0 = to_cnt;
        pulse_start();
        repeat (600) @(posedge clk); @(negedge clk);
        chk(to_cnt == t0 + 1, "R10 timeout pulse", to_cnt, t0 + 1);
        chk(!adc_convst, "R10 convst dropped", adc_convst, 0);
        no_busy = 0;

        // R11: continuous
        f0 = frames_done;
        @(posedge clk); #1 cont_en = 1;
        wait_frames(f0 + 3);
        chk(frames_done >= f0 + 3, "R11 repeated frames", frames_done, f0 + 3);
        @(posedge clk); #1 cont_en = 0;
        repeat (200) @(posedge clk);
        c0 = conv_rises;
        repeat (200) @(posedge clk); @(negedge clk);
        chk(conv_rises == c0 && !adc_convst, "R11 held low", conv_rises, c0);

        // R7: clamp on the 4-channel variant
        chk(c4_os == 3'd6, "R7 clamp code 7", c4_os, 6);
        chk(c4_rises == 0, "R7 no reset on small part", c4_rises, 0);
        finish_run();
    end
endmodule